// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns data words into asynchronous serial frames on a single output line. Software-side logic writes a word into a one-deep holding register. On the next bit tick the word moves into a shift register and goes out. Each frame has a low start bit and 8 or 9 data bits, least significant first. When parity is on, a parity bit takes the place of the top data bit. The frame ends with one or two high stop bits.

An external divider supplies the bit tick: a one-cycle pulse per bit period. The line changes only on edges where that pulse is high. Two status outputs let the writer pace itself. The data-register-empty flag shows that the holding register can take a new word. The transmission-complete flag shows that the line has gone idle after the last frame. A word written while a frame is in flight follows it with no idle gap.

Top module: `sfx_tx`

## Requirements
- R1: `txd` is 1 after reset and whenever no frame is in progress. Each frame starts with one 0 bit, sends its data bits least significant first, and ends with stop bits of value 1.
- R2: When `cfg_long` is 1, a frame carries `wr_data[8:0]` as 9 data bits. When it is 0, the frame carries `wr_data[7:0]` as 8 data bits.
- R3: When `cfg_par_en` is 1, the last data slot of the selected length (bit 8 in long mode, bit 7 in short mode) carries a parity bit instead of the data bit. For even parity (`cfg_par_odd`=0) that bit is the XOR of the data bits below it. For odd parity it is the inverse of that XOR.
- R4: `cfg_two_stop`=1 gives two stop bits, and 0 gives one stop bit.
- R5: `txd` changes only on a clock edge where `bit_tick` is 1, apart from the forced return to idle in R9.
- R6: `dre` is 1 after reset and falls on the edge after a write on `wr_valid`. A frame starts on the first `bit_tick` edge at which a word is held and the transmitter is enabled. On that edge the word leaves the holding register and `dre` rises.
- R7: A word held when the last stop bit ends starts its start bit on that same tick, with no idle bit between the frames.
- R8: `tc` is 0 after reset and stays 0 while a frame is in progress. It is set on the tick edge that ends the last stop bit when no word is held. It is cleared on the edge after a write.
- R9: The transmitter runs only while both `glb_en` and `tx_en` are 1. Dropping either one returns `txd` to 1 on the next edge and abandons the current frame. A held word stays held and is sent once both enables are set again.
- R10: The frame configuration is sampled when a frame starts. Changing it mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| glb_en | input | 1 | Global block enable |
| tx_en | input | 1 | Transmitter enable |
| cfg_long | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit replaces top data bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to transmit |
| txd | output | 1 | Serial output line, idle high |
| dre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
The bench decodes the line at every bit tick and compares each frame bit by bit with a frame it builds itself. Random words go out under all sixteen combinations of length, parity enable, parity sense and stop count, so a wrong parity sense, a misplaced parity slot or a missing stop bit each shows up as a distinct bit mismatch. Groups of two or three words written back to back separate gapless chaining from a design that idles between frames. Directed cases cover three further behaviours: the flag timing around a single frame, a frame cut off by dropping the enable, and a configuration change in the middle of a frame.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  typedef struct packed {
    logic long_word;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } sfx_cfg_t;

endpackage

// File: rtl/sfx_hold.sv
module sfx_hold #(
  parameter int MAX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [MAX_W-1:0] wr_data,
  input  logic             load,
  output logic [MAX_W-1:0] word,
  output logic             empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      word  <= '0;
    end else begin
      if (wr_valid) begin
        word  <= wr_data;
        empty <= 1'b0;
      end else if (load) begin
        empty <= 1'b1;
      end
    end
  end

  AST_WR_FILLS: assert property (@(posedge clk) disable iff (rst) wr_valid |=> !empty); // R6

endmodule

// File: rtl/sfx_frame.sv
module sfx_frame
  import sfx_pkg::*;
#(
  parameter int MAX_W = 9,
  localparam int FRAME_W = MAX_W + 3,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic [MAX_W-1:0]   word,
  input  sfx_cfg_t           cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);

  int unsigned nbits;
  int unsigned nstop;
  logic        par;

  always_comb begin
    nbits = cfg.long_word ? MAX_W : MAX_W - 1;
    nstop = cfg.two_stop ? 2 : 1;
    par   = cfg.par_odd;
    for (int i = 0; i < MAX_W - 1; i++) begin
      if (i < nbits - 1) par = par ^ word[i];
    end
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < nbits) begin
        if (cfg.par_en && (i == nbits - 1)) frame[1+i] = par;
        else                                frame[1+i] = word[i];
      end
    end
    len = CNT_W'(1 + nbits + nstop);
  end

endmodule

// File: rtl/sfx_shift.sv
module sfx_shift #(
  parameter int FRAME_W = 12,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               en,
  input  logic               held,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               txd,
  output logic               busy,
  output logic               load,
  output logic               done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic               last;

  assign last = busy && (left == '0);
  assign load = bit_tick && en && held && (!busy || last);
  assign done = bit_tick && en && last && !held;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      left <= '0;
      sh   <= '1;
    end else if (!en) begin
      txd  <= 1'b1;
      busy <= 1'b0;
    end else if (bit_tick) begin
      if (load) begin
        txd  <= frame[0];
        sh   <= {1'b1, frame[FRAME_W-1:1]};
        left <= len - ONE;
        busy <= 1'b1;
      end else if (busy) begin
        if (left != '0) begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - ONE;
        end else begin
          txd  <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  AST_TXD_TICK: assert property (@(posedge clk) disable iff (rst) (!bit_tick && en) |=> $stable(txd)); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !busy |-> txd); // R1
  AST_EN_OFF: assert property (@(posedge clk) disable iff (rst) !en |=> (txd && !busy)); // R9

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int MAX_W = 9,
  localparam int FRAME_W = MAX_W + 3,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             glb_en,
  input  logic             tx_en,
  input  logic             cfg_long,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             wr_valid,
  input  logic [MAX_W-1:0] wr_data,
  output logic             txd,
  output logic             dre,
  output logic             tc
);

  sfx_cfg_t           cfg;
  logic [MAX_W-1:0]   word;
  logic               empty;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               en;
  logic               busy;
  logic               load;
  logic               done;

  assign cfg = '{long_word: cfg_long, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign en  = glb_en && tx_en;
  assign dre = empty;

  sfx_hold #(.MAX_W(MAX_W)) hold_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .load(load), .word(word), .empty(empty)
  );

  sfx_frame #(.MAX_W(MAX_W)) frame_i (
    .word(word), .cfg(cfg), .frame(frame), .len(len)
  );

  sfx_shift #(.FRAME_W(FRAME_W)) shift_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .en(en), .held(!empty),
    .frame(frame), .len(len), .txd(txd), .busy(busy), .load(load), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst)           tc <= 1'b0;
    else if (wr_valid) tc <= 1'b0;
    else if (done)     tc <= 1'b1;
  end

  AST_DRE_ON_LOAD: assert property (@(posedge clk) disable iff (rst) (load && !wr_valid) |=> dre); // R6
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst) load |=> !txd); // R1
  AST_TC_CLEAR: assert property (@(posedge clk) disable iff (rst) wr_valid |=> !tc); // R8
  AST_TC_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !tc); // R8

endmodule

// File: tb/sfx_tx_tb_top.sv
module sfx_tx_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic glb_en = 1'b1;
  logic tx_en = 1'b1;
  logic cfg_long = 1'b0;
  logic cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0;
  logic cfg_two_stop = 1'b0;
  logic wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic txd, dre, tc;

  always #2 clk = ~clk;

  sfx_tx dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .glb_en(glb_en), .tx_en(tx_en),
    .cfg_long(cfg_long), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .dre(dre), .tc(tc)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [8:0] wq [0:255];
  int q_head = 0;
  int q_cnt = 0;

  bit         en_on = 1;
  bit         dec_busy = 0;
  int         dec_idx = 0;
  int         dec_len = 0;
  logic [3:0] dec_cfg = '0;
  logic [11:0] dec_bits = '1;
  int         frames_done = 0;
  logic       last_s = 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int frame_len(logic [3:0] c);
    return 1 + (c[3] ? 9 : 8) + (c[0] ? 2 : 1);
  endfunction

  // c = {long, par_en, par_odd, two_stop}
  function automatic logic [11:0] exp_frame(logic [8:0] w, logic [3:0] c);
    int n = c[3] ? 9 : 8;
    logic p = c[1];
    logic [11:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[1+i] = w[i];
    if (c[2]) begin
      for (int i = 0; i < n - 1; i++) p = p ^ w[i];
      f[n] = p;
    end
    return f;
  endfunction

  function automatic logic [11:0] len_mask(int l);
    logic [11:0] m = '0;
    for (int i = 0; i < l; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic observe(logic s);
    if (!en_on) begin
      chk("R9 idle while disabled", 32'(s), 32'd1);
    end else if (!dec_busy) begin
      if (q_cnt != 0) chk("R6 R7 start on tick with held word", 32'(s), 32'd0);
      else            chk("R1 idle high", 32'(s), 32'd1);
      if (s == 1'b0) begin
        dec_busy = 1;
        dec_cfg  = {cfg_long, cfg_par_en, cfg_par_odd, cfg_two_stop};
        dec_len  = frame_len(dec_cfg);
        dec_bits = '1;
        dec_bits[0] = 1'b0;
        dec_idx  = 1;
      end
    end else begin
      dec_bits[dec_idx] = s;
      dec_idx++;
      if (dec_idx == dec_len) begin
        chk("R1 R2 R3 R4 R10 frame bits", 32'(dec_bits & len_mask(dec_len)),
            32'(exp_frame(wq[q_head], dec_cfg) & len_mask(dec_len)));
        q_head = (q_head + 1) % 256;
        q_cnt--;
        dec_busy = 0;
        frames_done++;
      end
    end
  endtask

  task automatic tick_period();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    last_s = txd;
    observe(txd);
    repeat (2) begin
      @(negedge clk);
      if (txd !== last_s) chk("R5 line moves only on ticks", 32'(txd), 32'(last_s));
    end
  endtask

  task automatic write_word(logic [8:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_data = w;
    wq[(q_head + q_cnt) % 256] = w;
    q_cnt++;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic send(logic [8:0] w);
    while (!dre) tick_period();
    write_word(w);
  endtask

  task automatic drain();
    while (q_cnt != 0 || dec_busy) tick_period();
  endtask

  task automatic set_cfg(logic [3:0] c);
    @(negedge clk);
    {cfg_long, cfg_par_en, cfg_par_odd, cfg_two_stop} = c;
  endtask

  initial begin
    int seed_dummy;
    int f0;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset txd", 32'(txd), 32'd1);
    chk("R6 reset dre", 32'(dre), 32'd1);
    chk("R8 reset tc", 32'(tc), 32'd0);

    // single 8N1 frame with flag timing
    set_cfg(4'b0000);
    write_word(9'h0A5);
    chk("R6 dre falls after write", 32'(dre), 32'd0);
    tick_period();
    chk("R6 dre rises at load tick", 32'(dre), 32'd1);
    f0 = frames_done;
    while (frames_done == f0) tick_period();
    chk("R8 tc low during last stop bit", 32'(tc), 32'd0);
    tick_period();
    chk("R8 tc set after last stop bit", 32'(tc), 32'd1);
    write_word(9'h03C);
    chk("R8 tc cleared by write", 32'(tc), 32'd0);
    drain();
    tick_period();

    // back-to-back, 9 bits, even parity, 2 stop
    set_cfg(4'b1101);
    send(9'h1F0);
    send(9'h00F);
    send(9'h155);
    drain();
    tick_period();
    chk("R8 tc after chained frames", 32'(tc), 32'd1);

    // enable dropped mid-frame
    set_cfg(4'b0110);
    send(9'h0C3);
    repeat (4) tick_period();
    @(negedge clk); tx_en = 1'b0; en_on = 0;
    @(negedge clk);
    chk("R9 txd high after disable", 32'(txd), 32'd1);
    dec_busy = 0;
    q_head = (q_head + 1) % 256;
    q_cnt--;
    write_word(9'h081);
    repeat (5) tick_period();
    chk("R9 word stays held while disabled", 32'(dre), 32'd0);
    @(negedge clk); glb_en = 1'b0; tx_en = 1'b1;
    repeat (3) tick_period();
    chk("R9 global enable also gates", 32'(dre), 32'd0);
    @(negedge clk); glb_en = 1'b1; en_on = 1;
    tick_period();
    chk("R9 held word sent after enable", 32'(dre), 32'd1);
    drain();

    // configuration changed mid-frame
    set_cfg(4'b0000);
    send(9'h1E7);
    repeat (3) tick_period();
    set_cfg(4'b1111);
    drain();
    set_cfg(4'b0000);
    tick_period();

    // random groups
    for (int g = 0; g < 48; g++) begin
      int k;
      set_cfg(4'($urandom_range(0, 15)));
      k = $urandom_range(1, 3);
      for (int j = 0; j < k; j++) send(9'($urandom_range(0, 511)));
      drain();
      tick_period();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule